// File: doc/BRIEF.md
# Store Queue Commit and Drain Tracker

This block tracks stores held in a circular queue, from allocation through retirement. A store is allocated at the tail, where it records its sequence number and the load-queue tail at that moment. Later it becomes eligible to write back: either the commit stage releases every older store up to a sequence number, or a store-conditional executes without a fault. The memory side then reports each store's completion by index. Completions may arrive in any order. The head only moves when the head entry itself completes, and it then skips over every adjacent entry that had already completed.

On a misprediction, the tail retracts over stores younger than the squash point. The walk halts at the first store already eligible, because that store is committed and must survive. The block also reports free space to dispatch as the smaller of the free load and free store slots. Forming cache transactions and retrying blocked writes belong to neighbouring logic.

Top module: `sq_commit_drain`

## Requirements
- R1: The ring holds SQ_DEPTH+1 slots and indices wrap modulo SQ_DEPTH+1. full_o is high exactly when count_o equals SQ_DEPTH, which is the same as tail+1 (mod SQ_DEPTH+1) equalling head. An allocation presented while full has no effect.
- R2: An accepted allocation writes alloc_seq_i and alloc_ldtail_i into slot tail_o. It advances the tail by one and raises count_o by one. head_seq_o and head_ldtail_o show the fields of the entry at head_o. An allocation in a cycle with squash_valid_i is ignored.
- R3: A commit walks from the head toward the tail. It skips entries already eligible, marks every other entry eligible, and adds one to wb_elig_cnt_o for each entry it marks. It stops at the first non-eligible entry whose sequence number is greater than commit_seq_i.
- R4: A store-conditional execution on an occupied, not-yet-eligible slot marks that slot eligible at once and adds one to wb_elig_cnt_o. The same event on an already eligible slot changes nothing.
- R5: A completion sets the slot's completed flag and lowers wb_elig_cnt_o by one.
- R6: A completion of the head slot retires it. The head then keeps advancing, and count_o keeps falling, while the next slot is occupied and already completed.
- R7: A completion of a slot other than the head leaves head_o and count_o unchanged.
- R8: A squash walks backward from the tail. It removes entries whose sequence number exceeds squash_seq_i and stops at the first entry that is already eligible.
- R9: free_slots_o equals min(LQ_DEPTH - lq_count_i, SQ_DEPTH - count_o).
- R10: A commit and a completion in the same cycle both take effect, and wb_elig_cnt_o ends at old + marked - 1. Entries marked by a commit or a store-conditional in a cycle are protected from a squash in that same cycle.
- R11: After reset, head, tail, count and eligible count are all zero and full_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| alloc_valid_i | input | 1 | allocate a store at the tail |
| alloc_seq_i | input | SEQ_W | sequence number of the new store |
| alloc_ldtail_i | input | LQ_W | load-queue tail captured with the store |
| sc_exec_valid_i | input | 1 | store-conditional executed without fault |
| sc_exec_idx_i | input | IDX_W | slot of that store-conditional |
| commit_valid_i | input | 1 | commit up to a sequence number |
| commit_seq_i | input | SEQ_W | youngest committed sequence number |
| complete_valid_i | input | 1 | a store finished its write |
| complete_idx_i | input | IDX_W | slot that finished |
| squash_valid_i | input | 1 | squash younger stores |
| squash_seq_i | input | SEQ_W | stores newer than this are removed |
| lq_count_i | input | LQ_W | current load-queue occupancy |
| head_o | output | IDX_W | oldest slot |
| tail_o | output | IDX_W | next slot to allocate |
| count_o | output | CNT_W | occupied slots |
| wb_elig_cnt_o | output | CNT_W | stores eligible but not completed |
| full_o | output | 1 | queue full |
| free_slots_o | output | CNT_W | space reported to dispatch |
| head_seq_o | output | SEQ_W | sequence number at the head |
| head_ldtail_o | output | LQ_W | captured load tail at the head |

## Verification
The bench builds the block with SQ_DEPTH=3 (four slots) and LQ_DEPTH=4. With so few slots, the full boundary, index wrap, and a head jump spanning the whole queue are reached within a handful of allocations. Directed sequences reach out-of-order completion, store-conditional marking, squash stopping at a committed entry, and a commit and a completion landing in one cycle. A long randomized phase then mixes every command against an arithmetic model. A sweep over every load count checks the free-space minimum at each store occupancy visited.

// File: rtl/sq_pkg.sv
package sq_pkg;
  function automatic int unsigned wrap_add(int unsigned a, int unsigned b, int unsigned cap);
    int unsigned s;
    s = a + b;
    return (s >= cap) ? s - cap : s;
  endfunction

  function automatic int unsigned wrap_sub(int unsigned a, int unsigned b, int unsigned cap);
    return (a >= b) ? a - b : a + cap - b;
  endfunction
endpackage

// File: rtl/sq_commit_scan.sv
module sq_commit_scan #(
  parameter int unsigned CAP   = 9,
  parameter int unsigned SEQ_W = 16,
  parameter int unsigned CNT_W = 4
) (
  input  logic             commit_valid_i,
  input  logic [SEQ_W-1:0] commit_seq_i,
  input  logic [CAP-1:0]   occ_i,
  input  logic [CAP-1:0]   elig_i,
  input  logic [SEQ_W-1:0] seq_i [CAP],
  output logic [CAP-1:0]   mark_o,
  output logic [CNT_W-1:0] n_mark_o
);
  // offset 0 is the head; walk toward the tail
  always_comb begin
    logic stop;
    int   n;
    stop   = 1'b0;
    n      = 0;
    mark_o = '0;
    for (int off = 0; off < int'(CAP); off++) begin
      if (commit_valid_i && !stop && occ_i[off] && !elig_i[off]) begin
        if (seq_i[off] > commit_seq_i) stop = 1'b1;
        else begin
          mark_o[off] = 1'b1;
          n = n + 1;
        end
      end
    end
    n_mark_o = CNT_W'(n);
  end
endmodule

// File: rtl/sq_squash_scan.sv
module sq_squash_scan #(
  parameter int unsigned CAP   = 9,
  parameter int unsigned SEQ_W = 16,
  parameter int unsigned CNT_W = 4
) (
  input  logic             squash_valid_i,
  input  logic [SEQ_W-1:0] squash_seq_i,
  input  logic [CAP-1:0]   occ_i,
  input  logic [CAP-1:0]   elig_i,
  input  logic [SEQ_W-1:0] seq_i [CAP],
  output logic [CNT_W-1:0] n_kill_o
);
  // offset 0 is the youngest entry (tail - 1)
  always_comb begin
    logic stop;
    int   n;
    stop = 1'b0;
    n    = 0;
    for (int off = 0; off < int'(CAP); off++) begin
      if (squash_valid_i && !stop) begin
        if (occ_i[off] && !elig_i[off] && seq_i[off] > squash_seq_i) n = n + 1;
        else stop = 1'b1;
      end
    end
    n_kill_o = CNT_W'(n);
  end
endmodule

// File: rtl/sq_drain_scan.sv
module sq_drain_scan #(
  parameter int unsigned CAP   = 9,
  parameter int unsigned CNT_W = 4
) (
  input  logic             trigger_i,
  input  logic [CAP-1:0]   occ_i,
  input  logic [CAP-1:0]   done_i,
  output logic [CNT_W-1:0] n_retire_o
);
  // count the leading run of completed entries from the head
  always_comb begin
    logic stop;
    int   n;
    stop = 1'b0;
    n    = 0;
    for (int off = 0; off < int'(CAP); off++) begin
      if (trigger_i && !stop) begin
        if (occ_i[off] && done_i[off]) n = n + 1;
        else stop = 1'b1;
      end
    end
    n_retire_o = CNT_W'(n);
  end
endmodule

// File: rtl/sq_free_calc.sv
module sq_free_calc #(
  parameter int unsigned SQ_DEPTH = 8,
  parameter int unsigned LQ_DEPTH = 8,
  parameter int unsigned CNT_W    = 4,
  parameter int unsigned LQ_W     = 4
) (
  input  logic [LQ_W-1:0]  lq_count_i,
  input  logic [CNT_W-1:0] sq_count_i,
  output logic [CNT_W-1:0] free_o
);
  always_comb begin
    int lq_free, sq_free;
    lq_free = int'(LQ_DEPTH) - int'(lq_count_i);
    sq_free = int'(SQ_DEPTH) - int'(sq_count_i);
    if (lq_free < 0) lq_free = 0;
    free_o = CNT_W'((lq_free < sq_free) ? lq_free : sq_free);
  end
endmodule

// File: rtl/sq_commit_drain.sv
module sq_commit_drain
  import sq_pkg::*;
#(
  parameter int unsigned SQ_DEPTH = 8,
  parameter int unsigned LQ_DEPTH = 8,
  parameter int unsigned SEQ_W    = 16,
  localparam int unsigned CAP     = SQ_DEPTH + 1,
  localparam int unsigned IDX_W   = $clog2(CAP),
  localparam int unsigned CNT_W   = $clog2(SQ_DEPTH + 1),
  localparam int unsigned LQ_W    = $clog2(LQ_DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_valid_i,
  input  logic [SEQ_W-1:0] alloc_seq_i,
  input  logic [LQ_W-1:0]  alloc_ldtail_i,
  input  logic             sc_exec_valid_i,
  input  logic [IDX_W-1:0] sc_exec_idx_i,
  input  logic             commit_valid_i,
  input  logic [SEQ_W-1:0] commit_seq_i,
  input  logic             complete_valid_i,
  input  logic [IDX_W-1:0] complete_idx_i,
  input  logic             squash_valid_i,
  input  logic [SEQ_W-1:0] squash_seq_i,
  input  logic [LQ_W-1:0]  lq_count_i,
  output logic [IDX_W-1:0] head_o,
  output logic [IDX_W-1:0] tail_o,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] wb_elig_cnt_o,
  output logic             full_o,
  output logic [CNT_W-1:0] free_slots_o,
  output logic [SEQ_W-1:0] head_seq_o,
  output logic [LQ_W-1:0]  head_ldtail_o
);
  logic [IDX_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] count_q, elig_cnt_q;
  logic [SEQ_W-1:0] seq_q [CAP];
  logic [LQ_W-1:0]  ld_q  [CAP];
  logic [CAP-1:0]   elig_q, done_q;

  logic [CAP-1:0]   occ_phys, sc_mark, elig_sc, cmark_phys, elig_mid;
  logic [CAP-1:0]   occ_f, elig_f, done_f, cmark_f;
  logic [SEQ_W-1:0] seq_f [CAP];
  logic [CAP-1:0]   occ_b, elig_b;
  logic [SEQ_W-1:0] seq_b [CAP];
  logic [CNT_W-1:0] n_cmark, n_kill, n_retire;
  logic             alloc_ok, drain_trig;

  assign full_o     = (count_q == CNT_W'(SQ_DEPTH));
  assign alloc_ok   = alloc_valid_i && !full_o && !squash_valid_i;
  assign drain_trig = complete_valid_i && (complete_idx_i == head_q) && (count_q != '0);

  // physical view: occupancy and store-conditional marks
  always_comb begin
    for (int i = 0; i < int'(CAP); i++) begin
      occ_phys[i] = wrap_sub(i, int'(head_q), CAP) < int'(count_q);
      sc_mark[i]  = sc_exec_valid_i && (int'(sc_exec_idx_i) == i) && occ_phys[i] && !elig_q[i];
      elig_sc[i]  = elig_q[i] | sc_mark[i];
    end
  end

  // head-relative view for commit and drain
  always_comb begin
    for (int off = 0; off < int'(CAP); off++) begin
      int idx;
      idx         = int'(wrap_add(int'(head_q), off, CAP));
      occ_f[off]  = off < int'(count_q);
      elig_f[off] = elig_sc[idx];
      seq_f[off]  = seq_q[idx];
      done_f[off] = done_q[idx] | (complete_valid_i && int'(complete_idx_i) == idx);
    end
  end

  sq_commit_scan #(.CAP(CAP), .SEQ_W(SEQ_W), .CNT_W(CNT_W)) u_commit (
    .commit_valid_i (commit_valid_i),
    .commit_seq_i   (commit_seq_i),
    .occ_i          (occ_f),
    .elig_i         (elig_f),
    .seq_i          (seq_f),
    .mark_o         (cmark_f),
    .n_mark_o       (n_cmark)
  );

  sq_drain_scan #(.CAP(CAP), .CNT_W(CNT_W)) u_drain (
    .trigger_i  (drain_trig),
    .occ_i      (occ_f),
    .done_i     (done_f),
    .n_retire_o (n_retire)
  );

  always_comb begin
    for (int i = 0; i < int'(CAP); i++) begin
      cmark_phys[i] = cmark_f[wrap_sub(i, int'(head_q), CAP)];
      elig_mid[i]   = elig_sc[i] | cmark_phys[i];
    end
  end

  // tail-relative view for squash, seeing this cycle's marks
  always_comb begin
    for (int off = 0; off < int'(CAP); off++) begin
      int idx;
      idx         = int'(wrap_sub(int'(tail_q), off + 1, CAP));
      occ_b[off]  = off < int'(count_q);
      elig_b[off] = elig_mid[idx];
      seq_b[off]  = seq_q[idx];
    end
  end

  sq_squash_scan #(.CAP(CAP), .SEQ_W(SEQ_W), .CNT_W(CNT_W)) u_squash (
    .squash_valid_i (squash_valid_i),
    .squash_seq_i   (squash_seq_i),
    .occ_i          (occ_b),
    .elig_i         (elig_b),
    .seq_i          (seq_b),
    .n_kill_o       (n_kill)
  );

  sq_free_calc #(.SQ_DEPTH(SQ_DEPTH), .LQ_DEPTH(LQ_DEPTH), .CNT_W(CNT_W), .LQ_W(LQ_W)) u_free (
    .lq_count_i (lq_count_i),
    .sq_count_i (count_q),
    .free_o     (free_slots_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q     <= '0;
      tail_q     <= '0;
      count_q    <= '0;
      elig_cnt_q <= '0;
    end else begin
      head_q  <= IDX_W'(wrap_add(int'(head_q), int'(n_retire), CAP));
      if (squash_valid_i) tail_q <= IDX_W'(wrap_sub(int'(tail_q), int'(n_kill), CAP));
      else if (alloc_ok)  tail_q <= IDX_W'(wrap_add(int'(tail_q), 1, CAP));
      count_q <= CNT_W'(int'(count_q) - int'(n_retire) - int'(n_kill) + (alloc_ok ? 1 : 0));
      elig_cnt_q <= CNT_W'(int'(elig_cnt_q) + int'(n_cmark) + (|sc_mark ? 1 : 0)
                           - (complete_valid_i ? 1 : 0));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      elig_q <= '0;
      done_q <= '0;
      for (int i = 0; i < int'(CAP); i++) begin
        seq_q[i] <= '0;
        ld_q[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < int'(CAP); i++) begin
        if (alloc_ok && int'(tail_q) == i) begin
          seq_q[i]  <= alloc_seq_i;
          ld_q[i]   <= alloc_ldtail_i;
          elig_q[i] <= 1'b0;
          done_q[i] <= 1'b0;
        end else begin
          elig_q[i] <= elig_mid[i];
          if (complete_valid_i && int'(complete_idx_i) == i) done_q[i] <= 1'b1;
        end
      end
    end
  end

  assign head_o        = head_q;
  assign tail_o        = tail_q;
  assign count_o       = count_q;
  assign wb_elig_cnt_o = elig_cnt_q;
  assign head_seq_o    = seq_q[head_q];
  assign head_ldtail_o = ld_q[head_q];

  assert_count_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(count_q) <= int'(SQ_DEPTH));

  assert_full_ring_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o == (wrap_add(int'(tail_q), 1, CAP) == int'(head_q)));

  assert_full_blocks_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !squash_valid_i) |=> $stable(tail_q));

  assert_elig_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    elig_cnt_q <= count_q);

  assert_head_moves_on_head_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drain_trig |=> $stable(head_q));

  assert_squash_keeps_head_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (squash_valid_i && !complete_valid_i) |=> $stable(head_q));

  assert_alloc_grows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_ok && !complete_valid_i) |=> (count_q == $past(count_q) + 1'b1));
endmodule

// File: tb/tb_sq_commit_drain.sv
module tb_sq_commit_drain;
  localparam int DEPTH = 3;
  localparam int LQD   = 4;
  localparam int CAP   = DEPTH + 1;
  localparam int SW    = 16;
  localparam int IW    = $clog2(CAP);
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int LW    = $clog2(LQD + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          a_v = 0, sc_v = 0, c_v = 0, d_v = 0, s_v = 0;
  logic [SW-1:0] a_seq = 0, c_seq = 0, s_seq = 0;
  logic [LW-1:0] a_ld = 0, lq = 0;
  logic [IW-1:0] sc_idx = 0, d_idx = 0;
  logic [IW-1:0] head, tail;
  logic [CW-1:0] count, elig, freeo;
  logic          full;
  logic [SW-1:0] hseq;
  logic [LW-1:0] hld;

  sq_commit_drain #(.SQ_DEPTH(DEPTH), .LQ_DEPTH(LQD), .SEQ_W(SW)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .alloc_valid_i(a_v), .alloc_seq_i(a_seq), .alloc_ldtail_i(a_ld),
    .sc_exec_valid_i(sc_v), .sc_exec_idx_i(sc_idx),
    .commit_valid_i(c_v), .commit_seq_i(c_seq),
    .complete_valid_i(d_v), .complete_idx_i(d_idx),
    .squash_valid_i(s_v), .squash_seq_i(s_seq),
    .lq_count_i(lq),
    .head_o(head), .tail_o(tail), .count_o(count), .wb_elig_cnt_o(elig),
    .full_o(full), .free_slots_o(freeo), .head_seq_o(hseq), .head_ldtail_o(hld)
  );

  int errors = 0, checks = 0;
  bit finished = 0;
  int seqctr = 10;

  int m_seq [CAP];
  int m_ld  [CAP];
  bit m_el  [CAP];
  bit m_dn  [CAP];
  int mh = 0, mt = 0, mc = 0, me = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit occupied(int idx);
    return ((idx - mh + CAP) % CAP) < mc;
  endfunction

  task automatic model_update();
    int mc0, h0, p;
    mc0 = mc; h0 = mh;
    if (sc_v && occupied(int'(sc_idx)) && !m_el[sc_idx]) begin
      m_el[sc_idx] = 1; me++;
    end
    if (c_v) begin
      p = mh;
      for (int k = 0; k < mc; k++) begin
        if (!m_el[p]) begin
          if (m_seq[p] > int'(c_seq)) break;
          m_el[p] = 1; me++;
        end
        p = (p + 1) % CAP;
      end
    end
    if (d_v) begin m_dn[d_idx] = 1; me--; end
    if (s_v) begin
      p = (mt + CAP - 1) % CAP;
      while (mc > 0 && m_seq[p] > int'(s_seq) && !m_el[p]) begin
        mt = p; mc--; p = (p + CAP - 1) % CAP;
      end
    end
    if (d_v && int'(d_idx) == h0 && mc > 0) begin
      do begin mh = (mh + 1) % CAP; mc--; end while (mc > 0 && m_dn[mh]);
    end
    if (a_v && !s_v && mc0 < DEPTH) begin
      m_seq[mt] = int'(a_seq); m_ld[mt] = int'(a_ld); m_el[mt] = 0; m_dn[mt] = 0;
      mt = (mt + 1) % CAP; mc++;
    end
  endtask

  task automatic compare_all();
    int lf, sf;
    lf = LQD - int'(lq); sf = DEPTH - mc;
    chk("R6", "head", int'(head), mh);
    chk("R2", "tail", int'(tail), mt);
    chk("R2", "count", int'(count), mc);
    chk("R3", "eligible count", int'(elig), me);
    chk("R1", "full", int'(full), (mc == DEPTH) ? 1 : 0);
    chk("R9", "free slots", int'(freeo), (lf < sf) ? lf : sf);
    if (mc > 0) begin
      chk("R2", "head seq", int'(hseq), m_seq[mh]);
      chk("R2", "head load tail", int'(hld), m_ld[mh]);
    end
  endtask

  // inputs are set at a negedge before calling; returns at the next negedge
  task automatic step();
    @(posedge clk);
    model_update();
    #1;
    compare_all();
    @(negedge clk);
    a_v = 0; sc_v = 0; c_v = 0; d_v = 0; s_v = 0;
  endtask

  task automatic do_alloc(input int ld);
    a_v = 1; a_seq = SW'(seqctr); a_ld = LW'(ld); seqctr++; step();
  endtask

  initial begin
    for (int i = 0; i < CAP; i++) begin
      m_seq[i] = 0; m_ld[i] = 0; m_el[i] = 0; m_dn[i] = 0;
    end
    repeat (3) @(negedge clk);
    chk("R11", "reset count", int'(count), 0);
    chk("R11", "reset head", int'(head), 0);
    chk("R11", "reset eligible", int'(elig), 0);
    chk("R11", "reset full", int'(full), 0);
    rst_n = 1;
    @(negedge clk);

    // fill: seq 10,11,12 in slots 0..2
    do_alloc(1); do_alloc(2); do_alloc(3);
    chk("R1", "full after depth allocations", int'(full), 1);
    a_v = 1; a_seq = 16'd99; a_ld = 0; step();
    chk("R1", "alloc while full ignored", int'(tail), 3);

    c_v = 1; c_seq = 16'd11; step();
    chk("R3", "commit marks two", int'(elig), 2);

    d_v = 1; d_idx = 1; step();
    chk("R7", "non-head completion keeps head", int'(head), 0);
    chk("R5", "completion lowers eligible", int'(elig), 1);

    sc_v = 1; sc_idx = 2; step();
    chk("R4", "store-conditional marked", int'(elig), 2);
    sc_v = 1; sc_idx = 2; step();
    chk("R4", "repeat store-conditional no effect", int'(elig), 2);

    s_v = 1; s_seq = 16'd9; step();
    chk("R8", "squash stops at eligible tail entry", int'(count), 3);

    d_v = 1; d_idx = 0; step();
    chk("R6", "head jumps over completed run", int'(head), 2);
    chk("R6", "count after jump", int'(count), 1);

    do_alloc(0); do_alloc(1);   // seq 13 slot 3, seq 14 slot 0 (wrap)
    chk("R1", "tail wrapped", int'(tail), 1);

    c_v = 1; c_seq = 16'd13; d_v = 1; d_idx = 2; step();
    chk("R10", "commit and completion together: eligible", int'(elig), 1);
    chk("R10", "commit and completion together: head", int'(head), 3);

    s_v = 1; s_seq = 16'd13; step();
    chk("R8", "squash removes younger only", int'(count), 1);
    chk("R8", "tail after squash", int'(tail), 0);

    // same-cycle commit protects against squash
    do_alloc(2);                // seq 15 slot 0
    c_v = 1; c_seq = 16'd15; s_v = 1; s_seq = 16'd12; step();
    chk("R10", "commit shields entry from same-cycle squash", int'(count), 2);

    // randomized mix
    for (int n = 0; n < 3000; n++) begin
      int r, off, p;
      lq = LW'($urandom_range(0, LQD));
      r = $urandom_range(0, 99);
      if (r < 40) begin a_v = 1; a_seq = SW'(seqctr); a_ld = LW'($urandom_range(0, LQD)); seqctr++; end
      if ($urandom_range(0, 3) == 0) begin c_v = 1; c_seq = SW'(seqctr - $urandom_range(0, 5)); end
      if ($urandom_range(0, 5) == 0) begin sc_v = 1; sc_idx = IW'($urandom_range(0, CAP - 1)); end
      if ($urandom_range(0, 9) == 0) begin s_v = 1; s_seq = SW'(seqctr - $urandom_range(0, 4)); end
      if ($urandom_range(0, 2) != 0 && mc > 0) begin
        off = $urandom_range(0, mc - 1);
        for (int k = 0; k < mc; k++) begin
          p = (mh + (off + k) % mc) % CAP;
          if (m_el[p] && !m_dn[p]) begin d_v = 1; d_idx = IW'(p); break; end
        end
      end
      step();
    end

    // free-space sweep over all load occupancies
    for (int l = 0; l <= LQD; l++) begin
      lq = LW'(l);
      #1;
      chk("R9", "free sweep", int'(freeo), ((LQD - l) < (DEPTH - mc)) ? (LQD - l) : (DEPTH - mc));
    end

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule